// File: doc/BRIEF.md
# Single-Slope PWM Timer with Buffered Compare

This block is a 16-bit up-counting pulse-width modulation generator. On every timer tick it steps its counter from zero up to a selectable TOP value and then clears back to zero, so one period is TOP+1 ticks. TOP comes from one of two places: a dedicated period register, or the channel-A compare register. Two compare channels drive one waveform pin each. A two-bit mode per channel picks one of four behaviours: output held low, toggle, normal PWM or inverted PWM.

The period register and both compare registers are double-buffered. A write lands in a shadow copy. The shadow moves into the working copy only on the tick that clears the counter, so a period that is already running is never cut short or stretched. Each wrap also raises a one-cycle overflow pulse. The tick comes from an external prescaler as a one-cycle enable. A typical prescaler divides by 1, 8, 64, 256 or 1024. Between ticks the counter and the pins hold their values.

Top module: `pwm_timer_top`

## Requirements
- R1: A synchronous active-high reset clears the counter, all shadow and working registers, both waveform pins and the overflow pulse to zero.
- R2: The counter advances by one only on a clock where `tick_en` is high. On a tick where it equals TOP it returns to zero, and `ovf_pulse` is high for exactly the following clock cycle. One pulse therefore appears every TOP+1 ticks.
- R3: With `top_src` = 0 the working period register is TOP. With `top_src` = 1 the working channel-A compare register is TOP.
- R4: A write updates only the shadow copy. The working copy takes the shadow value at the wrap tick. A write in that same cycle stays in the shadow until the next wrap.
- R5: Mode code 2 (normal PWM): the pin goes high in the cycle after a wrap tick. It goes low in the cycle after a tick on which the count equals the channel compare value and is not TOP.
- R6: Mode code 3 gives the exact complement of the mode 2 waveform: the pin goes low after a wrap and high after a compare match.
- R7: With a compare value of zero, mode 2 gives a one-tick high spike once every TOP+1 ticks, and mode 3 gives a one-tick low spike.
- R8: With a compare value equal to or above TOP, mode 2 holds the pin constantly high and mode 3 holds it constantly low.
- R9: Mode code 1 on channel A with `top_src` = 1 inverts the pin at every match, which is also every wrap. This gives a 50% duty square wave with a period of 2·(TOP+1) ticks. With TOP = 0 the pin changes on every tick.
- R10: Mode code 0 holds the pin low. Mode code 1 also holds the pin low on channel B, and on channel A while `top_src` = 0.
- R11: On clocks without a tick, the counter, both pins in modes 1 to 3, and the overflow pulse keep their values (the pulse stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled timer tick, one clock wide |
| top_src | input | 1 | TOP select: 0 period register, 1 channel-A compare |
| per_we | input | 1 | Write strobe, period shadow |
| per_wdata | input | 16 | Period write data |
| cmpa_we | input | 1 | Write strobe, channel-A compare shadow |
| cmpa_wdata | input | 16 | Channel-A compare write data |
| cmpb_we | input | 1 | Write strobe, channel-B compare shadow |
| cmpb_wdata | input | 16 | Channel-B compare write data |
| mode_a | input | 2 | Channel-A output mode (0 off, 1 toggle, 2 PWM, 3 inverted PWM) |
| mode_b | input | 2 | Channel-B output mode (same codes) |
| wave_a | output | 1 | Channel-A waveform |
| wave_b | output | 1 | Channel-B waveform |
| ovf_pulse | output | 1 | One-cycle pulse after each wrap |

## Verification
The bench builds the block with its default 16-bit counter width. It drives small TOP values (0, 5 and 9), so that full periods, spikes, constant levels and the fastest toggle rate all show up within a few hundred cycles. It switches its own tick generator between dividing by 1 and dividing by 8. This shows that events happen only on ticks and that period length scales with the tick rate. Writes are placed in the middle of a period and in the cycle of a wrap, so that the one-wrap delay of the double buffer can be seen on the pins.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    OM_OFF     = 2'd0,
    OM_TOGGLE  = 2'd1,
    OM_PWM     = 2'd2,
    OM_PWM_INV = 2'd3
  } out_mode_e;

  typedef enum logic {
    TOP_FROM_PER  = 1'b0,
    TOP_FROM_CMPA = 1'b1
  } top_sel_e;

  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned NUM_BUF = 3;

  localparam int unsigned BUF_PER  = 0;
  localparam int unsigned BUF_CMPA = 1;
  localparam int unsigned BUF_CMPB = 2;

endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] active
);

  logic [W-1:0] shadow_q;

  // Transfer first reads the old shadow, so a write in the wrap cycle waits a period.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active   <= '0;
    end else begin
      if (load)  active   <= shadow_q;
      if (wr_en) shadow_q <= wr_data;
    end
  end

  assert_load_from_shadow_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> active == $past(shadow_q));

  assert_active_held_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active));

  assert_write_reaches_shadow_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> shadow_q == $past(wr_data));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         ovf
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic at_top;

  assign at_top = (cnt == top);
  assign wrap   = tick && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= wrap;
      if (wrap)      cnt <= '0;
      else if (tick) cnt <= cnt + ONE;
    end
  end

  assert_wrap_clears_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0) && ovf);

  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !at_top) |=> (cnt == $past(cnt) + ONE) && !ovf);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt) && !ovf);

endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan
  import pwm_timer_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter bit          TOGGLE_OK = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  out_mode_e    mode,
  input  logic         toggle_allow,
  output logic         wave
);

  logic tog_en;
  logic match;
  logic set_lvl;

  generate
    if (TOGGLE_OK) begin : g_toggle
      assign tog_en = toggle_allow;
    end else begin : g_no_toggle
      assign tog_en = 1'b0;
    end
  endgenerate

  assign match   = tick && (cnt == cmp);
  assign set_lvl = (mode == OM_PWM);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
    end else begin
      unique case (mode)
        OM_OFF: wave <= 1'b0;
        OM_TOGGLE: begin
          if (!tog_en)    wave <= 1'b0;
          else if (match) wave <= ~wave;
        end
        default: begin
          if (wrap)       wave <= set_lvl;
          else if (match) wave <= ~set_lvl;
        end
      endcase
    end
  end

  assert_off_low_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == OM_OFF || (mode == OM_TOGGLE && !tog_en)) |=> !wave);

  assert_wrap_high_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == OM_PWM && wrap) |=> wave);

  assert_wrap_low_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == OM_PWM_INV && wrap) |=> !wave);

  assert_toggle_flip_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == OM_TOGGLE && tog_en && match) |=> wave != $past(wave));

  assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!tick && (mode == OM_PWM || mode == OM_PWM_INV || (mode == OM_TOGGLE && tog_en)))
      |=> $stable(wave));

endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             top_src,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             cmpa_we,
  input  logic [CNT_W-1:0] cmpa_wdata,
  input  logic             cmpb_we,
  input  logic [CNT_W-1:0] cmpb_wdata,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  output logic             wave_a,
  output logic             wave_b,
  output logic             ovf_pulse
);

  logic             buf_we    [NUM_BUF];
  logic [CNT_W-1:0] buf_wdata [NUM_BUF];
  logic [CNT_W-1:0] buf_act   [NUM_BUF];

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_val;
  logic             wrap;
  top_sel_e         top_sel;

  out_mode_e        ch_mode [NUM_CH];
  logic [CNT_W-1:0] ch_cmp  [NUM_CH];
  logic             ch_wave [NUM_CH];

  assign buf_we[BUF_PER]     = per_we;
  assign buf_we[BUF_CMPA]    = cmpa_we;
  assign buf_we[BUF_CMPB]    = cmpb_we;
  assign buf_wdata[BUF_PER]  = per_wdata;
  assign buf_wdata[BUF_CMPA] = cmpa_wdata;
  assign buf_wdata[BUF_CMPB] = cmpb_wdata;

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BUF; gb++) begin : g_buf
      pwm_shadow_reg #(.W(CNT_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_we[gb]),
        .wr_data (buf_wdata[gb]),
        .load    (wrap),
        .active  (buf_act[gb])
      );
    end
  endgenerate

  assign top_sel = top_sel_e'(top_src);
  assign top_val = (top_sel == TOP_FROM_CMPA) ? buf_act[BUF_CMPA] : buf_act[BUF_PER];

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_en),
    .top  (top_val),
    .cnt  (cnt),
    .wrap (wrap),
    .ovf  (ovf_pulse)
  );

  assign ch_mode[0] = out_mode_e'(mode_a);
  assign ch_mode[1] = out_mode_e'(mode_b);
  assign ch_cmp[0]  = buf_act[BUF_CMPA];
  assign ch_cmp[1]  = buf_act[BUF_CMPB];

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
      pwm_out_chan #(.W(CNT_W), .TOGGLE_OK(gc == 0)) u_ch (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_en),
        .wrap         (wrap),
        .cnt          (cnt),
        .cmp          (ch_cmp[gc]),
        .mode         (ch_mode[gc]),
        .toggle_allow (top_sel == TOP_FROM_CMPA),
        .wave         (ch_wave[gc])
      );
    end
  endgenerate

  assign wave_a = ch_wave[0];
  assign wave_b = ch_wave[1];

  assert_ovf_single_R2: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> cnt == '0);

  assert_top_source_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && top_src && cnt == buf_act[BUF_CMPA]) |=> ovf_pulse);

endmodule

// File: tb/sim_pwm_timer_top.sv
module sim_pwm_timer_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic         top_src = 1'b0;
  logic         per_we = 1'b0, cmpa_we = 1'b0, cmpb_we = 1'b0;
  logic [W-1:0] per_wdata = '0, cmpa_wdata = '0, cmpb_wdata = '0;
  logic [1:0]   mode_a = 2'd0, mode_b = 2'd0;
  logic         wave_a, wave_b, ovf_pulse;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int tick_div = 1;
  int div_cnt = 0;
  bit tick_hold = 1'b0;
  int cycle = 0;

  // reference model state
  int m_cnt = 0;
  int m_sh[3];
  int m_act[3];
  bit m_wa = 0, m_wb = 0, m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer_top #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .top_src(top_src),
    .per_we(per_we), .per_wdata(per_wdata),
    .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata),
    .cmpb_we(cmpb_we), .cmpb_wdata(cmpb_wdata),
    .mode_a(mode_a), .mode_b(mode_b),
    .wave_a(wave_a), .wave_b(wave_b), .ovf_pulse(ovf_pulse)
  );

  function automatic bit next_pin(int mode, int cmp, bit cur, bit tk, bit wr, int cnt, bit tog_ok);
    bit lvl;
    if (mode == 0) return 1'b0;
    if (mode == 1) begin
      if (!tog_ok) return 1'b0;
      if (tk && cnt == cmp) return !cur;
      return cur;
    end
    lvl = (mode == 2);
    if (wr) return lvl;
    if (tk && cnt == cmp) return !lvl;
    return cur;
  endfunction

  always @(posedge clk) begin
    int top;
    bit wr;
    cycle++;
    if (rst) begin
      m_cnt = 0; m_wa = 0; m_wb = 0; m_ovf = 0;
      for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    end else begin
      top = top_src ? m_act[1] : m_act[0];
      wr  = tick_en && (m_cnt == top);
      m_wa  = next_pin(mode_a, m_act[1], m_wa, tick_en, wr, m_cnt, top_src);
      m_wb  = next_pin(mode_b, m_act[2], m_wb, tick_en, wr, m_cnt, 1'b0);
      m_ovf = wr;
      if (wr) begin
        m_cnt = 0;
        for (int i = 0; i < 3; i++) m_act[i] = m_sh[i];
      end else if (tick_en) m_cnt = m_cnt + 1;
      if (per_we)  m_sh[0] = per_wdata;
      if (cmpa_we) m_sh[1] = cmpa_wdata;
      if (cmpb_we) m_sh[2] = cmpb_wdata;
    end
  end

  // tick source and per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (wave_a !== m_wa || wave_b !== m_wb || ovf_pulse !== m_ovf) begin
        errors++;
        $display("FAIL %s cycle %0d: actual a=%b b=%b ovf=%b expected a=%b b=%b ovf=%b",
                 cur_req, cycle, wave_a, wave_b, ovf_pulse, m_wa, m_wb, m_ovf);
      end
    end
    if (rst || tick_hold) begin
      tick_en = 1'b0;
      div_cnt = 0;
    end else begin
      tick_en = (div_cnt == 0);
      div_cnt = (div_cnt + 1) % tick_div;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(int which, int val);
    @(negedge clk);
    case (which)
      0: begin per_we = 1; per_wdata = W'(val); end
      1: begin cmpa_we = 1; cmpa_wdata = W'(val); end
      default: begin cmpb_we = 1; cmpb_wdata = W'(val); end
    endcase
    @(negedge clk);
    per_we = 0; cmpa_we = 0; cmpb_we = 0;
  endtask

  // counts high cycles of each output and changes of wave_a over n cycles
  task automatic measure(int n, output int ha, output int hb, output int ho, output int ta);
    bit prev;
    ha = 0; hb = 0; ho = 0; ta = 0;
    @(negedge clk);
    prev = wave_a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ha += wave_a; hb += wave_b; ho += ovf_pulse;
      if (wave_a != prev) ta++;
      prev = wave_a;
    end
  endtask

  initial begin
    int ha, hb, ho, ta;
    bit sa, sb;
    idle(3);
    check("R1 wave_a after reset", wave_a, 0);
    check("R1 wave_b after reset", wave_b, 0);
    check("R1 ovf after reset", ovf_pulse, 0);
    rst = 1'b0;
    idle(2);

    cur_req = "R5";
    mode_a = 2; mode_b = 3; top_src = 0;
    wr(0, 9); wr(1, 3); wr(2, 0);
    idle(30);
    measure(60, ha, hb, ho, ta);
    check("R2 pulses in 60 ticks, TOP=9", ho, 6);
    check("R5 high cycles, cmp=3", ha, 24);
    check("R7 inverted spike, cmp=0", hb, 54);

    cur_req = "R8";
    mode_b = 2;
    wr(2, 9);
    idle(25);
    measure(60, ha, hb, ho, ta);
    check("R8 cmp=TOP mode 2 constant high", hb, 60);
    wr(2, 20);
    mode_b = 3;
    idle(25);
    measure(40, ha, hb, ho, ta);
    check("R8 cmp>TOP mode 3 constant low", hb, 0);
    mode_b = 2;
    wr(2, 0);
    idle(25);
    measure(60, ha, hb, ho, ta);
    check("R7 spike, cmp=0 mode 2", hb, 6);
    mode_b = 3;
    measure(60, ha, hb, ho, ta);
    check("R6 inverted after mode switch", hb, 54);

    cur_req = "R4";
    idle(4);
    wr(0, 4);
    idle(3);
    wr(1, 2);
    idle(30);
    measure(50, ha, hb, ho, ta);
    check("R4 new period after wrap, TOP=4", ho, 10);
    check("R4 new compare after wrap", ha, 30);

    cur_req = "R9";
    top_src = 1;
    mode_a = 1;
    wr(1, 5);
    idle(30);
    measure(120, ha, hb, ho, ta);
    check("R3 period from channel A compare", ho, 20);
    check("R9 toggle 50% duty", ha, 60);
    check("R9 toggle transitions", ta, 20);
    wr(1, 0);
    idle(20);
    measure(20, ha, hb, ho, ta);
    check("R9 TOP=0 toggles every tick", ta, 20);

    cur_req = "R10";
    mode_b = 1;
    top_src = 0;
    idle(10);
    measure(40, ha, hb, ho, ta);
    check("R10 channel A mode 1 without compare TOP", ha, 0);
    check("R10 channel B mode 1", hb, 0);
    mode_a = 0;
    measure(20, ha, hb, ho, ta);
    check("R10 mode 0 low", ha, 0);

    cur_req = "R11";
    mode_a = 2; mode_b = 3;
    tick_div = 8;
    wr(0, 9); wr(1, 3); wr(2, 0);
    idle(200);
    measure(240, ha, hb, ho, ta);
    check("R11 pulses with divide-by-8 tick", ho, 3);
    check("R11 high cycles with divide-by-8 tick", ha, 96);
    tick_hold = 1;
    @(negedge clk);
    sa = wave_a; sb = wave_b;
    measure(30, ha, hb, ho, ta);
    check("R11 wave_a held without ticks", ha, sa ? 30 : 0);
    check("R11 wave_b held without ticks", hb, sb ? 30 : 0);
    check("R11 no pulse without ticks", ho, 0);
    tick_hold = 0;
    idle(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule